// File: doc/BRIEF.md
# Write-Through Accelerator Cache Controller

This controller lets a fast 8-bit processor run from a local byte cache while the system memory it mirrors sits on a slow 1 MHz bus. It is direct-mapped, with one byte per line. Each line is tagged with the upper CPU address bits and the bank number of the bank-switched auxiliary RAM. A read that hits returns in the same fast cycle. All other accesses stall the processor and become a single-byte transaction on the slow bus, which uses a request/acknowledge handshake.

Writes always go out on the slow bus. A write updates the local copy only when that line already holds the same address and bank, so the cache never holds data newer than system memory. Some address ranges are never cached: the I/O page, and the expansion ROM window whose bank switching the controller cannot see. The upper ROM range is cached only while a configuration input allows it. This lets the controller work next to RAM cards that overlay that range.

The processor holds its access, with `cpu_req` high and the other CPU inputs stable, until a cycle in which `cpu_stall` is low. The access completes in that cycle.

Top module: `wt_accel_cache`

## Requirements
- R1: A read of a cacheable address whose line is valid and whose tag matches (upper address bits `cpu_addr[15:INDEX_W]` together with `cpu_bank`) completes in the same cycle: `cpu_stall` is low and `cpu_rdata` carries the cached byte. No bus request is made.
- R2: A read that misses a cacheable address raises `cpu_stall`. The next cycle raises `bus_req` with `bus_we`=0. The access completes with `bus_rdata` in the cycle after `bus_ack`. The line is then filled, so a repeat of the same read hits.
- R3: Every write stalls and produces exactly one bus write carrying its address, bank and data. The write completes in the cycle after `bus_ack`.
- R4: A write to a cacheable line that hits updates the cached byte. A write that misses leaves the cache unchanged (no allocation), so a later read of that address misses.
- R5: The same address under a different `cpu_bank` is a different line tag. It misses, and filling it evicts the other bank's copy at that index.
- R6: Addresses 0xC000–0xC0FF skip the tag lookup. Reads there always use the bus and are never filled.
- R7: Addresses 0xC800–0xCFFF are never cached. Every read there uses the bus.
- R8: Addresses 0xD000–0xFFFF are cached only while `rom_cache_en`=1, sampled with the access. With it at 0, reads there always use the bus, even for a line filled earlier.
- R9: Reset invalidates every line, so the first read of any address after reset misses.
- R10: `bus_req`, `bus_addr`, `bus_bank`, `bus_we` and `bus_wdata` stay stable from the rise of `bus_req` until `bus_ack`. `bus_req` drops in the cycle after `bus_ack`, and is never raised by a read hit.
- R11: Addresses 0xC100–0xC7FF are cacheable like ordinary RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_bank | input | BANK_W | Current auxiliary RAM bank |
| rom_cache_en | input | 1 | Allow caching of 0xD000–0xFFFF |
| cpu_rdata | output | 8 | Read data to CPU |
| cpu_stall | output | 1 | Hold the current access |
| bus_req | output | 1 | Slow-bus transaction request |
| bus_we | output | 1 | Slow-bus write |
| bus_addr | output | 16 | Slow-bus address |
| bus_bank | output | BANK_W | Slow-bus bank select |
| bus_wdata | output | 8 | Slow-bus write data |
| bus_rdata | input | 8 | Slow-bus read data |
| bus_ack | input | 1 | Slow-bus transaction done |

## Verification
The assertions check four things on every cycle:
- every write turns into a bus write carrying its data;
- reads of the I/O page and of the expansion ROM window always stall;
- reads of the upper ROM range stall while caching of that range is off;
- the bus request holds steady until acknowledged and drops afterwards.

Other behaviours depend on earlier history, so only the bench's scenarios can show them. These are whether a repeat read hits after a fill, how a write hit differs from a write miss, eviction between banks, and invalidation by reset. The bench's model predicts the stall, the bus request and the returned byte on every cycle, with slow-bus latency varying between transactions.

// File: rtl/wt_accel_cache.sv
module wt_accel_cache #(
  parameter int INDEX_W = 10,
  parameter int BANK_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic [BANK_W-1:0] cpu_bank,
  input  logic              rom_cache_en,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_stall,
  output logic              bus_req,
  output logic              bus_we,
  output logic [15:0]       bus_addr,
  output logic [BANK_W-1:0] bus_bank,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  input  logic              bus_ack
);
  localparam int DEPTH = 1 << INDEX_W;
  localparam int TAG_W = 16 - INDEX_W + BANK_W;

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_DONE} state_t;

  state_t               state;
  logic [DEPTH-1:0]     valid;
  logic [TAG_W-1:0]     tag_mem [DEPTH];
  logic [7:0]           data_mem [DEPTH];
  logic [INDEX_W-1:0]   q_idx;
  logic [TAG_W-1:0]     q_tag;
  logic                 q_ok, q_hit;
  logic [7:0]           rd_q;

  function automatic logic cacheable(input logic [15:0] a, input logic rom_en);
    if (a[15:8] == 8'hC0)      return 1'b0;
    if (a[15:11] == 5'b11001)  return 1'b0;
    if (a[15:12] >= 4'hD)      return rom_en;
    return 1'b1;
  endfunction

  wire [INDEX_W-1:0] idx      = cpu_addr[INDEX_W-1:0];
  wire [TAG_W-1:0]   tag      = {cpu_addr[15:INDEX_W], cpu_bank};
  wire               cpu_ok   = cacheable(cpu_addr, rom_cache_en);
  wire               line_hit = cpu_ok && valid[idx] && (tag_mem[idx] == tag);
  wire               fast_hit = (state == S_IDLE) && cpu_req && !cpu_we && line_hit;
  wire               fill     = (state == S_BUS) && bus_ack;

  assign cpu_stall = cpu_req && (state != S_DONE) && !fast_hit;
  assign cpu_rdata = (state == S_DONE) ? rd_q : data_mem[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      valid     <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_bank  <= '0;
      bus_wdata <= '0;
      rd_q      <= '0;
      q_idx     <= '0;
      q_tag     <= '0;
      q_ok      <= 1'b0;
      q_hit     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (cpu_req && !fast_hit) begin
          state     <= S_BUS;
          bus_req   <= 1'b1;
          bus_we    <= cpu_we;
          bus_addr  <= cpu_addr;
          bus_bank  <= cpu_bank;
          bus_wdata <= cpu_wdata;
          q_idx     <= idx;
          q_tag     <= tag;
          q_ok      <= cpu_ok;
          q_hit     <= line_hit;
        end
        S_BUS: if (bus_ack) begin
          state   <= S_DONE;
          bus_req <= 1'b0;
          rd_q    <= bus_rdata;
          if (!bus_we && q_ok) valid[q_idx] <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (fill && !bus_we && q_ok) begin
      tag_mem[q_idx]  <= q_tag;
      data_mem[q_idx] <= bus_rdata;
    end else if (fill && bus_we && q_hit) begin
      data_mem[q_idx] <= bus_wdata;
    end
  end

  assert_write_goes_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && cpu_req && cpu_we) |=> (bus_req && bus_we && bus_wdata == $past(cpu_wdata)));

  assert_io_read_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && cpu_addr[15:8] == 8'hC0 && state != S_DONE) |-> cpu_stall);

  assert_rom_window_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && cpu_addr[15:11] == 5'b11001 && state != S_DONE) |-> cpu_stall);

  assert_rom_off_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && !rom_cache_en && cpu_addr[15:12] >= 4'hD && state != S_DONE) |-> cpu_stall);

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_bank)));

  assert_bus_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> !bus_req);
endmodule

// File: tb/tb_wt_accel_cache.sv
module tb_wt_accel_cache;
  localparam int IW = 10;
  localparam int BW = 5;

  typedef struct {
    bit          we;
    logic [15:0] a;
    logic [4:0]  b;
    logic [7:0]  d;
    bit          rom;
    string       r;
  } op_t;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0, rom_cache_en = 0, bus_ack = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0, bus_rdata = 0;
  logic [BW-1:0] cpu_bank = 0;
  logic [7:0]  cpu_rdata, bus_wdata;
  logic        cpu_stall, bus_req, bus_we;
  logic [15:0] bus_addr;
  logic [BW-1:0] bus_bank;

  wt_accel_cache #(.INDEX_W(IW), .BANK_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_bank(cpu_bank), .rom_cache_en(rom_cache_en),
    .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_bank(bus_bank), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack));

  always #5 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 0;
  op_t q[$];
  op_t cur;
  bit active = 0, gap = 0, cur_hit = 0;
  int bus_seen = 0, wcnt = 0, lat = 0;
  logic [7:0] exp_rd;
  logic [7:0] mem [int];
  int ctag [int];
  logic [7:0] cdat [int];

  task automatic chk(bit ok, string r, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", r, what, act, exp, $time);
    end
  endtask

  function automatic bit cach(logic [15:0] a, bit rom);
    if (a[15:8] == 8'hC0) return 0;
    if (a >= 16'hC800 && a <= 16'hCFFF) return 0;
    if (a >= 16'hD000) return rom;
    return 1;
  endfunction

  function automatic int key(logic [4:0] b, logic [15:0] a);
    return int'(b) * 65536 + int'(a);
  endfunction

  function automatic logic [7:0] rdm(int k);
    if (mem.exists(k)) return mem[k];
    return 8'(k * 13 + 5);
  endfunction

  function automatic int tagv(logic [4:0] b, logic [15:0] a);
    return int'(b) * 1024 + int'(a) / (1 << IW);
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (active) begin
        int ix;
        ix = int'(cur.a) % (1 << IW);
        if (cur_hit) begin
          chk(cpu_stall == 0, cur.r, "hit stall", cpu_stall, 0);
          chk(bus_req == 0, cur.r, "hit bus_req", bus_req, 0);
          chk(cpu_rdata == exp_rd, cur.r, "hit rdata", cpu_rdata, exp_rd);
          active = 0; gap = 1;
        end else begin
          chk(cpu_stall == !bus_ack, cur.r, "miss stall", cpu_stall, !bus_ack);
          chk(bus_req == !bus_ack, cur.r, "bus_req", bus_req, !bus_ack);
          if (bus_ack) begin
            chk(bus_seen == 1, cur.r, "bus transactions", bus_seen, 1);
            if (!cur.we) begin
              chk(cpu_rdata == exp_rd, cur.r, "miss rdata", cpu_rdata, exp_rd);
              if (cach(cur.a, cur.rom)) begin ctag[ix] = tagv(cur.b, cur.a); cdat[ix] = exp_rd; end
            end else begin
              mem[key(cur.b, cur.a)] = cur.d;
              if (cach(cur.a, cur.rom) && ctag.exists(ix) && ctag[ix] == tagv(cur.b, cur.a))
                cdat[ix] = cur.d;
            end
            active = 0; gap = 1;
          end
        end
      end else begin
        chk(bus_req == 0, "R10", "idle bus_req", bus_req, 0);
        chk(cpu_stall == 0, "R10", "idle stall", cpu_stall, 0);
      end

      if (bus_ack) begin
        bus_ack = 0; wcnt = 0;
      end else if (bus_req) begin
        if (wcnt >= lat) begin
          chk(bus_addr == cur.a, cur.r, "bus_addr", bus_addr, cur.a);
          chk(bus_bank == cur.b, cur.r, "bus_bank", bus_bank, cur.b);
          chk(bus_we == cur.we, cur.r, "bus_we", bus_we, cur.we);
          if (cur.we) chk(bus_wdata == cur.d, "R3", "bus_wdata", bus_wdata, cur.d);
          bus_rdata = rdm(key(bus_bank, bus_addr));
          bus_ack = 1; bus_seen++;
          lat = (lat + 2) % 5;
        end else wcnt++;
      end

      if (!active && gap) begin
        gap = 0; cpu_req = 0;
      end else if (!active && q.size() > 0) begin
        int ix;
        cur = q.pop_front();
        ix = int'(cur.a) % (1 << IW);
        cpu_req = 1; cpu_we = cur.we; cpu_addr = cur.a; cpu_bank = cur.b;
        cpu_wdata = cur.d; rom_cache_en = cur.rom;
        cur_hit = !cur.we && cach(cur.a, cur.rom) && ctag.exists(ix) && ctag[ix] == tagv(cur.b, cur.a);
        exp_rd = cur_hit ? cdat[ix] : rdm(key(cur.b, cur.a));
        bus_seen = 0;
        active = 1;
      end else if (!active) cpu_req = 0;
    end
  end

  task automatic run(bit we, logic [15:0] a, logic [4:0] b, logic [7:0] d, bit rom, string r);
    op_t o;
    o.we = we; o.a = a; o.b = b; o.d = d; o.rom = rom; o.r = r;
    q.push_back(o);
    do @(posedge clk); while (q.size() > 0 || active || gap);
  endtask

  task automatic expect_hit(bit want, logic [15:0] a, logic [4:0] b, bit rom, string r);
    int ix;
    ix = int'(a) % (1 << IW);
    chk((cach(a, rom) && ctag.exists(ix) && ctag[ix] == tagv(b, a)) == want, r, "model hit plan", !want, want);
    run(0, a, b, 0, rom, r);
  endtask

  task automatic do_reset();
    @(posedge clk); #2 rst_n = 0;
    cpu_req = 0; bus_ack = 0; active = 0; gap = 0; wcnt = 0;
    ctag.delete(); cdat.delete();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(cpu_stall == 0, "R9", "reset stall", cpu_stall, 0);
    chk(bus_req == 0, "R9", "reset bus_req", bus_req, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    do_reset();
    expect_hit(0, 16'h1234, 0, 0, "R2");
    expect_hit(1, 16'h1234, 0, 0, "R1");
    run(1, 16'h1234, 0, 8'hA5, 0, "R3");
    expect_hit(1, 16'h1234, 0, 0, "R4");
    run(1, 16'h0300, 0, 8'h5A, 0, "R4");
    expect_hit(0, 16'h0300, 0, 0, "R4");
    expect_hit(0, 16'h1234, 3, 0, "R5");
    expect_hit(1, 16'h1234, 3, 0, "R5");
    expect_hit(0, 16'h1234, 0, 0, "R5");
    expect_hit(0, 16'hC030, 0, 1, "R6");
    expect_hit(0, 16'hC030, 0, 1, "R6");
    expect_hit(0, 16'hC0FF, 0, 1, "R6");
    run(1, 16'hC050, 0, 8'h11, 1, "R3");
    expect_hit(0, 16'hC800, 0, 1, "R7");
    expect_hit(0, 16'hC800, 0, 1, "R7");
    expect_hit(0, 16'hCFFF, 1, 1, "R7");
    expect_hit(0, 16'hCFFF, 1, 1, "R7");
    expect_hit(0, 16'hC7FF, 0, 0, "R11");
    expect_hit(1, 16'hC7FF, 0, 0, "R11");
    expect_hit(0, 16'hD000, 0, 0, "R8");
    expect_hit(0, 16'hD000, 0, 0, "R8");
    expect_hit(0, 16'hE123, 2, 1, "R8");
    expect_hit(1, 16'hE123, 2, 1, "R8");
    expect_hit(0, 16'hE123, 2, 0, "R8");
    expect_hit(1, 16'hE123, 2, 1, "R8");
    run(1, 16'hE123, 2, 8'h3C, 1, "R4");
    expect_hit(1, 16'hE123, 2, 1, "R4");
    expect_hit(0, 16'h0001, 31, 0, "R2");
    expect_hit(1, 16'h0001, 31, 0, "R1");
    do_reset();
    expect_hit(0, 16'h1234, 3, 0, "R9");
    expect_hit(0, 16'h0001, 31, 0, "R9");
    expect_hit(1, 16'h0001, 31, 0, "R1");
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule